// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves a translation-buffer miss in hardware. When the buffer misses, it hands the walker a virtual address. The walker then reads the page table held in memory and reports the result, and no software is involved on the success path. The 32-bit virtual address has three fields. The top 10 bits index the first-level table. The next 10 bits index the second-level table. The low 12 bits are the page offset, which the walker never uses.

The walk starts from a root pointer that the surrounding logic supplies. The first-level entry gives the frame that holds the second-level table. The second-level entry gives the physical page number. The outcome depends on the entries read:
- If both entries are present, the walker emits a one-cycle fill for the translation buffer.
- If either entry is absent, it emits a one-cycle fault instead. The fault carries the full faulting virtual address and the level that failed, so trap logic can report it precisely.

While a walk is in progress, the walker raises a busy flag and does not accept another miss. Memory reads use a request channel with a valid/ready handshake and a separate response channel that carries a valid strobe.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: A miss is accepted when `miss_valid` is 1 and `busy` is 0. The first memory read then goes to `root_base + vaddr[31:22]*4`.
- R3: A table entry is present when its bit 0 is 1, and its frame number is bits [31:12]. The second read goes to `{L1[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: When the second-level entry is present, `fill_valid` is 1 for exactly one cycle. During that cycle `fill_vpn` is `vaddr[31:20+12-20]`, meaning `vaddr[31:12]`, and `fill_ppn` is `L2[31:12]`. No fault is raised.
- R5: When the first-level entry is absent, `fault_valid` is 1 for exactly one cycle, with `fault_vaddr` equal to the miss address and `fault_level` 0. No second read is issued and no fill occurs.
- R6: When the second-level entry is absent, `fault_valid` is 1 for exactly one cycle, with `fault_level` 1 and `fault_vaddr` equal to the miss address. No fill occurs.
- R7: `busy` is 1 from the cycle after acceptance until the fill or fault cycle ends. A miss presented while `busy` is 1 is ignored and does not start a walk.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` does not change.
- R9: A `mem_rsp_valid` pulse that arrives while no response is awaited is ignored.
- R10: `root_base` is sampled when the miss is accepted. Later changes to it do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Byte address of the first-level table |
| miss_valid | input | 1 | Translation miss present |
| miss_vaddr | input | 32 | Virtual address that missed |
| busy | output | 1 | Walk in progress; misses are not accepted |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read |
| fill_valid | output | 1 | One-cycle translation fill strobe |
| fill_vpn | output | 20 | Virtual page number to fill |
| fill_ppn | output | 20 | Physical page number to fill |
| fault_valid | output | 1 | One-cycle page-fault strobe |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_level | output | 1 | 0 if the first-level entry failed, 1 if the second-level entry failed |

## Verification
The hardest cases to provoke from the ports are the ones where the memory side misbehaves in the middle of a walk. These are a response strobe that arrives while the walker is still waiting for its request to be accepted, a root pointer that changes after acceptance, and a second miss held high during the walk. Each of them needs stimulus that is aligned to a particular walk state. The bench therefore serves each read by hand from tasks. It stretches the ready wait so that it can inject a stray response and modify `root_base` and `miss_vaddr` in exact cycles. It then confirms that the resulting read addresses and the fill contents still follow from the original miss alone.

// File: rtl/pw_pkg.sv
// Package: shared state encoding for the page-table walker.
// Assumes: nothing beyond standard SystemVerilog.
package pw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD1,
        WS_WT1,
        WS_RD2,
        WS_WT2,
        WS_FILL,
        WS_FAULT
    } walk_state_t;

endpackage

// File: rtl/pw_entry_addr.sv
// Module: pw_entry_addr
// Forms the byte address of one table entry from a table base and an index.
// Entries are four-byte words.
// Assumes: the index is narrower than ADDR_W - 2 bits.
module pw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    // Add the word-scaled index to the base.
    always_comb begin
        entry_addr = table_base + {{PAD_W{1'b0}}, index, 2'b00};
    end
endmodule

// File: rtl/pw_entry_decode.sv
// Module: pw_entry_decode
// Splits a table entry word into its present bit (bit 0) and its frame number (upper bits).
// Assumes: the bits between bit 0 and the offset boundary carry no meaning for the walk.
module pw_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       entry,
    output logic                    present,
    output logic [ADDR_W-OFF_W-1:0] frame
);
    logic unused_attr;

    // Pull the fields out of the word.
    always_comb begin
        present     = entry[0];
        frame       = entry[ADDR_W-1:OFF_W];
        unused_attr = ^entry[OFF_W-1:1];
    end
endmodule

// File: rtl/pw_walk_fsm.sv
// Module: pw_walk_fsm
// Sequences the walk: it accepts a miss, issues two entry reads, and then ends in a
// one-cycle fill or a one-cycle fault. It holds the walk context (address, root, frames).
// Assumes: memory returns exactly one response per accepted request; responses that
// arrive outside a wait state are ignored.
module pw_walk_fsm
    import pw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    localparam int PFN_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_vaddr,
    output logic              busy,
    input  logic [ADDR_W-1:0] l1_entry_addr,
    input  logic [ADDR_W-1:0] l2_entry_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic              rsp_present,
    input  logic [PFN_W-1:0]  rsp_frame,
    output logic [ADDR_W-1:0] vaddr_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [PFN_W-1:0]  l2_frame_q,
    output logic              fill_valid,
    output logic [PFN_W-1:0]  fill_ppn,
    output logic              fault_valid,
    output logic              fault_level
);
    walk_state_t state_q, state_d;
    logic [PFN_W-1:0] ppn_q;
    logic             lvl_q;
    logic             accept;

    assign accept = (state_q == WS_IDLE) && miss_valid;

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (miss_valid) state_d = WS_RD1;
            WS_RD1:   if (mem_req_ready) state_d = WS_WT1;
            WS_WT1:   if (mem_rsp_valid) state_d = rsp_present ? WS_RD2 : WS_FAULT;
            WS_RD2:   if (mem_req_ready) state_d = WS_WT2;
            WS_WT2:   if (mem_rsp_valid) state_d = rsp_present ? WS_FILL : WS_FAULT;
            WS_FILL:  state_d = WS_IDLE;
            WS_FAULT: state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Capture the walk context: miss address and root at acceptance, then each entry as it returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q    <= '0;
            base_q     <= '0;
            l2_frame_q <= '0;
            ppn_q      <= '0;
            lvl_q      <= 1'b0;
        end else begin
            if (accept) begin
                vaddr_q <= miss_vaddr;
                base_q  <= root_base;
            end
            if (state_q == WS_WT1 && mem_rsp_valid) begin
                l2_frame_q <= rsp_frame;
                lvl_q      <= 1'b0;
            end
            if (state_q == WS_WT2 && mem_rsp_valid) begin
                ppn_q <= rsp_frame;
                lvl_q <= 1'b1;
            end
        end
    end

    // Outputs are decoded from the state alone.
    always_comb begin
        busy          = (state_q != WS_IDLE);
        mem_req_valid = (state_q == WS_RD1) || (state_q == WS_RD2);
        mem_req_addr  = (state_q == WS_RD2) ? l2_entry_addr : l1_entry_addr;
        fill_valid    = (state_q == WS_FILL);
        fill_ppn      = ppn_q;
        fault_valid   = (state_q == WS_FAULT);
        fault_level   = lvl_q;
    end

    // R8: a request that is not accepted stays asserted with the same address.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: the fill strobe lasts one cycle.
    a_r4_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R5: the fault strobe lasts one cycle.
    a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    // R6: fill and fault are never reported together.
    a_r6_fill_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    // R7: an accepted miss makes the walker busy in the next cycle.
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> busy);

    // R10: the captured root does not change while a walk is running.
    a_r10_root_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(base_q));
endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Two-level page-table walker. It turns a translation-buffer miss into a fill or a
// precise page fault by reading one entry per level from memory.
// Assumes: 4-byte entries, present bit at bit 0, and the frame number in the bits above the offset.
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int IDX1_W = 10,
    parameter int IDX2_W = 10,
    localparam int OFF_W  = ADDR_W - IDX1_W - IDX2_W,
    localparam int VPN_W  = IDX1_W + IDX2_W,
    localparam int PFN_W  = ADDR_W - OFF_W,
    localparam int LEVELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_vaddr,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PFN_W-1:0]  fill_ppn,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic              fault_level
);
    logic [ADDR_W-1:0] vaddr_q, base_q;
    logic [PFN_W-1:0]  l2_frame_q;
    logic [ADDR_W-1:0] entry_addr [LEVELS];
    logic              rsp_present;
    logic [PFN_W-1:0]  rsp_frame;

    // One address generator per table level; each level takes its own index field.
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        if (g == 0) begin : g_top
            pw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX1_W)) u_addr (
                .table_base (base_q),
                .index      (vaddr_q[ADDR_W-1 -: IDX1_W]),
                .entry_addr (entry_addr[g])
            );
        end else begin : g_leaf
            pw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX2_W)) u_addr (
                .table_base ({l2_frame_q, {OFF_W{1'b0}}}),
                .index      (vaddr_q[OFF_W +: IDX2_W]),
                .entry_addr (entry_addr[g])
            );
        end
    end

    pw_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
        .entry   (mem_rsp_data),
        .present (rsp_present),
        .frame   (rsp_frame)
    );

    pw_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_base     (root_base),
        .miss_valid    (miss_valid),
        .miss_vaddr    (miss_vaddr),
        .busy          (busy),
        .l1_entry_addr (entry_addr[0]),
        .l2_entry_addr (entry_addr[1]),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_present   (rsp_present),
        .rsp_frame     (rsp_frame),
        .vaddr_q       (vaddr_q),
        .base_q        (base_q),
        .l2_frame_q    (l2_frame_q),
        .fill_valid    (fill_valid),
        .fill_ppn      (fill_ppn),
        .fault_valid   (fault_valid),
        .fault_level   (fault_level)
    );

    // The reported page and fault address both come from the captured miss.
    always_comb begin
        fill_vpn    = vaddr_q[ADDR_W-1:OFF_W];
        fault_vaddr = vaddr_q;
    end
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_vaddr = '0;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_level;

    int checks = 0;
    int fails  = 0;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fault_valid(fault_valid),
        .fault_vaddr(fault_vaddr), .fault_level(fault_level)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Serve one entry read: wait for the request, hold ready low for rw cycles, then respond after lw cycles.
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] word,
                         input int rw, input int lw, input bit stray, input string req);
        int guard = 0;
        while (!mem_req_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(mem_req_valid && mem_req_addr == exp_addr, req, mem_req_addr, exp_addr);
        for (int i = 0; i < rw; i++) begin
            if (stray && i == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_F001;
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check(mem_req_valid && mem_req_addr == exp_addr, "R8 request held",
                  mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < lw; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = word;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    // Full walk engine with expected values derived from the address and table words.
    task automatic do_walk(input logic [31:0] va, input logic [31:0] base,
                           input logic [31:0] l1, input logic [31:0] l2,
                           input int rw, input int lw, input bit stray,
                           input bit hold_miss, input bit move_base);
        logic [31:0] a1, a2;
        a1 = base + {20'h0, va[31:22], 2'b00};
        a2 = {l1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        @(negedge clk);
        root_base  = base;
        miss_valid = 1'b1;
        miss_vaddr = va;
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after accept", {31'h0, busy}, 32'h1);
        if (hold_miss) miss_vaddr = 32'hDEAD_B000;
        else           miss_valid = 1'b0;
        if (move_base) root_base = 32'h0BAD_0000;
        serve(a1, l1, rw, lw, stray, move_base ? "R10 root sampled" : "R2 first read address");
        miss_valid = 1'b0;
        if (!l1[0]) begin
            check(fault_valid && fault_vaddr == va, "R5 fault vaddr", fault_vaddr, va);
            check(fault_level == 1'b0 && !fill_valid, "R5 fault level 0",
                  {31'h0, fault_level}, 32'h0);
            @(negedge clk);
            check(!fault_valid && !mem_req_valid && !busy, "R5 single pulse, no second read",
                  {29'h0, fault_valid, mem_req_valid, busy}, 32'h0);
            return;
        end
        serve(a2, l2, rw, lw, 1'b0, stray ? "R9 stray ignored" : "R3 second read address");
        if (l2[0]) begin
            check(fill_valid && !fault_valid && fill_ppn == l2[31:12], "R4 fill ppn",
                  {12'h0, fill_ppn}, {12'h0, l2[31:12]});
            check(fill_vpn == va[31:12], "R4 fill vpn", {12'h0, fill_vpn}, {12'h0, va[31:12]});
            @(negedge clk);
            check(!fill_valid && !busy, "R4 single fill pulse",
                  {30'h0, fill_valid, busy}, 32'h0);
        end else begin
            check(fault_valid && !fill_valid && fault_vaddr == va, "R6 fault vaddr",
                  fault_vaddr, va);
            check(fault_level == 1'b1, "R6 fault level 1", {31'h0, fault_level}, 32'h1);
            @(negedge clk);
            check(!fault_valid && !fill_valid && !busy, "R6 single pulse",
                  {30'h0, fault_valid, busy}, 32'h0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 reset state",
              {28'h0, busy, mem_req_valid, fill_valid, fault_valid}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic_walks();
        do_walk(32'h1234_5678, 32'h0001_0000, 32'h0004_2001, 32'h000A_B001, 0, 0, 0, 0, 0);
        do_walk(32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_F003, 32'h1234_5FFF, 2, 3, 0, 0, 0);
        do_walk(32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_0001, 1, 0, 0, 0, 0);
    endtask

    task automatic t_l1_fault();
        do_walk(32'h4030_2010, 32'h0002_0000, 32'h0005_5FFE, 32'h0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_l2_fault();
        do_walk(32'hC00F_F123, 32'h0003_0000, 32'h0007_7001, 32'h0009_9000, 0, 2, 0, 0, 0);
    endtask

    // R7: a second miss held high during the walk is ignored and starts nothing afterwards.
    task automatic t_busy_holdoff();
        do_walk(32'h2468_ACE0, 32'h0004_0000, 32'h0006_6001, 32'h0003_3001, 1, 1, 0, 1, 0);
        repeat (3) @(negedge clk);
        check(!mem_req_valid && !busy, "R7 held miss not started",
              {30'h0, mem_req_valid, busy}, 32'h0);
    endtask

    task automatic t_stray_and_base();
        do_walk(32'h1357_9BDF, 32'h0005_0000, 32'h0008_8001, 32'h0007_7001, 3, 1, 1, 0, 0);
        do_walk(32'h7654_3210, 32'h0006_0000, 32'h0001_1001, 32'h000C_C001, 2, 1, 0, 0, 1);
    endtask

    initial begin
        #(5.0 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_walks();
        t_l1_fault();
        t_l2_fault();
        t_busy_holdoff();
        t_stray_and_base();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule